// File: doc/BRIEF.md
# Serial Port Receive-Timeout and Interrupt Controller

This block produces the interrupt request for a synchronous serial port that has transmit and receive FIFOs. At its centre is a receive idle timer. The timer counts serial bit-clock ticks while the receive FIFO holds data. It raises a timeout event when no new entry has arrived for a programmable number of ticks. That event joins six other event sources in a bank of sticky raw status bits. The bank has an enable mask and a write-one-to-clear register, and it drives a single registered interrupt line.

The port's datapath reports its FIFO state and event strobes to the block as single-cycle pulses or levels, all synchronous to the system clock. Software reads and writes through a small register interface. The interface has four word addresses and a one-cycle read latency. The end-of-transmission source only fires when the port is the bus master.

Top module: `ssp_irq_ctrl`

## Requirements
- R1: Out of reset, the raw status, the mask and the read data are all zero, the interrupt output is low, and the idle timer is loaded with its full count of TO_TICKS.
- R2: After the latest receive FIFO write, with the FIFO not empty, the receive-timeout raw bit (bit 1) sets at the clock edge of the TO_TICKS-th `bit_tick` pulse and not before. Cycles without a tick do not advance the timer.
- R3: Each `rx_push` reloads the timer to TO_TICKS, so the timeout comes TO_TICKS ticks after the last write.
- R4: While `rx_empty` is high, ticks do not advance the timer and the timeout bit never sets.
- R5: Bit 1 is cleared by writing 1 to bit 1 of the clear register, or by `rx_empty` being high at a clock edge.
- R6: A write-one clear of bit 1 reloads the timer. If data is still present, bit 1 sets again after another TO_TICKS ticks.
- R7: Writes to the clear register (address 3) clear only the bits written as 1; zero bits have no effect. A set event in the same cycle as its clear leaves the bit set.
- R8: Pulses on `ext_evt[0..4]` set the raw bits 0 (receive overrun), 2 (receive level), 3 (transmit level), 5 (receive DMA done) and 6 (transmit DMA done) respectively, and the bits stay set until cleared.
- R9: Raw bit 4 (end of transmission) sets only in a cycle where `is_master`, `tx_last_bit` and `tx_empty` are all high.
- R10: The masked status is raw AND mask (mask bit 1 = enabled). `irq` is the OR of the masked status, registered one cycle after the status changes.
- R11: Register map: address 0 = mask (read/write), 1 = raw status, 2 = masked status, 3 = clear (reads as 0). `csr_rdata` shows the addressed register one cycle after the address is presented. Writes to addresses 1 and 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_empty | input | 1 | Receive FIFO is empty (level) |
| rx_push | input | 1 | One entry written into the receive FIFO this cycle |
| bit_tick | input | 1 | One-cycle strobe per serial bit-clock period |
| is_master | input | 1 | Port operates as bus master |
| tx_last_bit | input | 1 | Shifter finished the last bit this cycle |
| tx_empty | input | 1 | Transmit FIFO is empty (level) |
| ext_evt | input | 5 | Event pulses: overrun, rx level, tx level, rx DMA done, tx DMA done |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register word address |
| csr_wdata | input | 7 | Register write data |
| csr_rdata | output | 7 | Registered read data |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench builds the block with TO_TICKS = 5. This puts every reload point within the timeout window, and every tick count before and at expiry, in a short sweep. The same short period lets the re-arm and same-cycle clear cases repeat cheaply. With only seven status bits, the bench sweeps all 128 mask values against all 64 patterns of the six directly driven sources, and checks the masked readback and the interrupt line for each pair.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
  localparam int NSRC = 7;
  localparam int NEXT = 5;

  // Raw status bit positions
  localparam int B_OVR   = 0;
  localparam int B_RXTO  = 1;
  localparam int B_RXLVL = 2;
  localparam int B_TXLVL = 3;
  localparam int B_EOT   = 4;
  localparam int B_RXDMA = 5;
  localparam int B_TXDMA = 6;

  // Register word addresses
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_RAW  = 2'd1;
  localparam logic [1:0] A_MIS  = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  typedef logic [NSRC-1:0] srcvec_t;

  // Maps external event input index to raw bit position
  function automatic int ext_pos(input int idx);
    case (idx)
      0:       return B_OVR;
      1:       return B_RXLVL;
      2:       return B_TXLVL;
      3:       return B_RXDMA;
      default: return B_TXDMA;
    endcase
  endfunction
endpackage

// File: rtl/ssp_rxto_timer.sv
module ssp_rxto_timer #(
  parameter int TO_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_empty,
  input  logic rx_push,
  input  logic bit_tick,
  input  logic rearm,
  output logic expire
);
  localparam int CW = $clog2(TO_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(TO_TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= FULL;
    else if (rx_push || rearm)
      cnt <= FULL;
    else if (!rx_empty && bit_tick && cnt != '0)
      cnt <= cnt - ONE;
  end

  // Last tick of the window while data waits and nothing new arrives
  assign expire = !rx_empty && bit_tick && !rx_push && (cnt == ONE);

  AST_RELOAD_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> cnt == FULL); // R3
  AST_HOLD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && !rx_push && !rearm) |=> $stable(cnt)); // R4
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !rx_push && !rearm) |=> $stable(cnt)); // R2
endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
  import ssp_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  srcvec_t set_v,
  input  srcvec_t clr_v,
  input  srcvec_t auto_clr,
  input  logic    mask_we,
  input  srcvec_t mask_wd,
  output srcvec_t raw_q,
  output srcvec_t mask_q,
  output logic    irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_v & ~auto_clr) | set_v;
      if (mask_we)
        mask_q <= mask_wd;
      irq_q <= |(raw_q & mask_q);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((raw_q & $past(set_v)) == $past(set_v))); // R7
  AST_ZERO_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (set_v == '0 && clr_v == '0 && auto_clr == '0) |=> $stable(raw_q)); // R7
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == |($past(raw_q) & $past(mask_q)))); // R10
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
  import ssp_irq_pkg::*;
#(
  parameter int TO_TICKS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_empty,
  input  logic            rx_push,
  input  logic            bit_tick,
  input  logic            is_master,
  input  logic            tx_last_bit,
  input  logic            tx_empty,
  input  logic [NEXT-1:0] ext_evt,
  input  logic            csr_we,
  input  logic [1:0]      csr_addr,
  input  logic [NSRC-1:0] csr_wdata,
  output logic [NSRC-1:0] csr_rdata,
  output logic            irq
);
  srcvec_t set_v, clr_v, auto_clr, raw_q, mask_q;
  logic    expire, mask_we, rd_irq;

  assign clr_v   = (csr_we && csr_addr == A_CLR) ? csr_wdata : '0;
  assign mask_we = csr_we && (csr_addr == A_MASK);

  always_comb begin
    set_v = '0;
    for (int i = 0; i < NEXT; i++)
      set_v[ext_pos(i)] = ext_evt[i];
    set_v[B_RXTO] = expire;
    set_v[B_EOT]  = is_master && tx_last_bit && tx_empty;
    auto_clr         = '0;
    auto_clr[B_RXTO] = rx_empty;
  end

  ssp_rxto_timer #(.TO_TICKS(TO_TICKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .rx_empty (rx_empty),
    .rx_push  (rx_push),
    .bit_tick (bit_tick),
    .rearm    (clr_v[B_RXTO]),
    .expire   (expire)
  );

  ssp_irq_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .set_v    (set_v),
    .clr_v    (clr_v),
    .auto_clr (auto_clr),
    .mask_we  (mask_we),
    .mask_wd  (csr_wdata),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq_q    (rd_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)
      csr_rdata <= '0;
    else
      case (csr_addr)
        A_MASK:  csr_rdata <= mask_q;
        A_RAW:   csr_rdata <= raw_q;
        A_MIS:   csr_rdata <= raw_q & mask_q;
        default: csr_rdata <= '0;
      endcase
  end

  assign irq = rd_irq;

  AST_RXTO_GONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !raw_q[B_RXTO]); // R5
  AST_EOT_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!is_master && !raw_q[B_EOT]) |=> !raw_q[B_EOT]); // R9
  AST_RXTO_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q[B_RXTO]) |-> $past(bit_tick)); // R2
endmodule

// File: tb/ssp_irq_ctrl_test.sv
module ssp_irq_ctrl_test;
  localparam int TO = 5;
  localparam int NS = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_empty = 1'b1, rx_push = 1'b0, bit_tick = 1'b0;
  logic is_master = 1'b0, tx_last_bit = 1'b0, tx_empty = 1'b0;
  logic [4:0] ext_evt = '0;
  logic csr_we = 1'b0;
  logic [1:0] csr_addr = '0;
  logic [NS-1:0] csr_wdata = '0;
  logic [NS-1:0] csr_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssp_irq_ctrl #(.TO_TICKS(TO)) uut (
    .clk(clk), .rst(rst), .rx_empty(rx_empty), .rx_push(rx_push),
    .bit_tick(bit_tick), .is_master(is_master), .tx_last_bit(tx_last_bit),
    .tx_empty(tx_empty), .ext_evt(ext_evt), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [NS-1:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d; step();
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    csr_addr = a; step(); d = int'(csr_rdata);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step(); bit_tick = 1'b0; step();
    end
  endtask

  task automatic push();
    rx_push = 1'b1; rx_empty = 1'b0; step(); rx_push = 1'b0;
  endtask

  task automatic drain();
    rx_empty = 1'b1; step();
    wr(2'd3, 7'h7F);
  endtask

  function automatic int expand(int p);
    return (p & 1) | (((p >> 1) & 1) << 2) | (((p >> 2) & 1) << 3) |
           (((p >> 3) & 1) << 4) | (((p >> 4) & 1) << 5) | (((p >> 5) & 1) << 6);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int d;
    step(); step(); rst = 1'b0;
    // R1 and R11: reset state
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reset readback", d, 0);
    end

    // R2: expiry exactly at the TO-th tick
    push();
    ticks(TO - 1); rd(2'd1, d); chk("R2 before expiry", d, 0);
    ticks(1);      rd(2'd1, d); chk("R2 at expiry", d, 2);
    drain();

    // R3: reload at every point of the window
    for (int j = 0; j < TO; j++) begin
      push(); ticks(j); push();
      ticks(TO - 1); rd(2'd1, d); chk("R3 reload no early", d, 0);
      ticks(1);      rd(2'd1, d); chk("R3 reload expiry", d, 2);
      drain();
    end

    // R4: ticks while empty do nothing
    rx_empty = 1'b1;
    ticks(3 * TO); rd(2'd1, d); chk("R4 empty no timeout", d, 0);
    chk("R4 irq low", int'(irq), 0);

    // R5: clear by FIFO empty
    push(); ticks(TO); rd(2'd1, d); chk("R5 set", d, 2);
    rx_empty = 1'b1; step(); rd(2'd1, d); chk("R5 empty clears", d, 0);

    // R5 / R6: write-one clear and re-arm with data still present
    push(); ticks(TO);
    wr(2'd3, 7'h02); rd(2'd1, d); chk("R5 w1c clears", d, 0);
    ticks(TO - 1); rd(2'd1, d); chk("R6 rearm no early", d, 0);
    ticks(1);      rd(2'd1, d); chk("R6 rearm fires", d, 2);

    // R7: zero write has no effect
    wr(2'd3, 7'h00); rd(2'd1, d); chk("R7 zero clear", d, 2);
    // R7: expiry coincides with its clear, set wins
    wr(2'd3, 7'h02); ticks(TO - 1);
    bit_tick = 1'b1; csr_we = 1'b1; csr_addr = 2'd3; csr_wdata = 7'h02; step();
    bit_tick = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    rd(2'd1, d); chk("R7 expire beats clear", d, 2);
    // R6: the coincident clear re-armed the timer
    wr(2'd3, 7'h02);
    ticks(TO - 1); rd(2'd1, d); chk("R6 rearm after tie", d, 0);
    drain();
    // R7: event pulse beats same-cycle clear
    ext_evt = 5'b00001; csr_we = 1'b1; csr_addr = 2'd3; csr_wdata = 7'h01; step();
    ext_evt = '0; csr_we = 1'b0; csr_wdata = '0;
    rd(2'd1, d); chk("R7 event beats clear", d, 1);
    drain();

    // R8: each external event lands on its bit and sticks
    for (int i = 0; i < 5; i++) begin
      ext_evt = 5'(1 << i); step(); ext_evt = '0; step(); step();
      rd(2'd1, d);
      chk("R8 event position", d, expand((i < 3) ? (1 << i) : (1 << (i + 1))));
      drain();
    end

    // R9: end of transmission needs all three conditions
    for (int c = 0; c < 8; c++) begin
      is_master = c[0]; tx_last_bit = c[1]; tx_empty = c[2]; step();
      is_master = 1'b0; tx_last_bit = 1'b0; tx_empty = 1'b0;
      rd(2'd1, d); chk("R9 eot gating", d, (c == 7) ? 16 : 0);
      drain();
    end

    // R10: all masks against all direct-source patterns
    for (int m = 0; m < 128; m++) begin
      for (int p = 0; p < 64; p++) begin
        wr(2'd3, 7'h7F); wr(2'd0, 7'(m));
        ext_evt = {p[5], p[4], p[2], p[1], p[0]};
        is_master = p[3]; tx_last_bit = p[3]; tx_empty = p[3];
        step();
        ext_evt = '0; is_master = 1'b0; tx_last_bit = 1'b0; tx_empty = 1'b0;
        rd(2'd2, d);
        chk("R10 masked status", d, expand(p) & m);
        chk("R10 irq", int'(irq), ((expand(p) & m) != 0) ? 1 : 0);
      end
    end

    // R10: timeout source through the mask
    wr(2'd3, 7'h7F); wr(2'd0, 7'h02);
    push(); ticks(TO); chk("R10 irq from timeout", int'(irq), 1);
    drain(); step(); chk("R10 irq drops", int'(irq), 0);

    // R11: writes to status addresses ignored, clear reads zero
    wr(2'd0, 7'h55);
    ext_evt = 5'b00101; step(); ext_evt = '0;
    wr(2'd1, 7'h00); wr(2'd2, 7'h7F);
    rd(2'd1, d); chk("R11 raw unaffected", d, expand(5'b00101 & 5'b00101) & 7'h7F);
    rd(2'd0, d); chk("R11 mask readback", d, 7'h55);
    rd(2'd3, d); chk("R11 clear reads zero", d, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule